// File: doc/BRIEF.md
# Parallel Byte-Programming Sequencer for a Code-plus-Data Non-Volatile Store

This block drives a non-volatile memory in a byte-wide parallel programming mode. One address space holds two arrays: a code array at the bottom and a smaller data array directly above it. A programmer presents an operation code, an address and a data byte. A rising edge on the program strobe then starts one operation: a byte write, a lock-bit update or a chip erase. The block gates every operation on a programming-enable level. After an accepted operation it holds `busy` high for a configured number of cycles, which stands in for the self-timed cell write. Verify reads return array contents through a registered output.

Parallel writes have no automatic erase, so cells can only move from 1 to 0. Rewriting a byte that is not blank leaves the AND of the old and new values and raises a sticky error. Three lock bits restrict what a programmer may do. The first forbids byte writes. The second replaces verify data with a fixed value. The third is stored only, for logic outside this block. A chip erase is the one way back: it blanks both arrays and clears every lock bit. Both arrays are modelled as on-chip register arrays, and the synchronous reset puts everything in the as-shipped state.

Top module: `nvm_parallel_programmer`

## Requirements
- R1: The code array covers addresses 0 to 2^CODE_AW-1. The data array covers the next 2^DATA_AW addresses. With defaults (CODE_AW=11, DATA_AW=9) these are 000h-7FFh and 800h-9FFh. With CODE_AW=13 and DATA_AW=11 they are 0000h-1FFFh and 2000h-27FFh.
- R2: After reset every byte of both arrays reads FFh, all lock bits are clear, `busy` is 0, `dout` is FFh and `overwrite_err` is 0.
- R3: One operation starts on a clock edge where `strobe` is 1 and was 0 at the previous edge, and only while `prog_en` is 1. The `op_sel` codes are 00 for verify (no strobe needed), 01 for byte write, 10 for lock program and 11 for chip erase.
- R4: An accepted byte write stores the old byte AND `din`. If the old byte was not FFh, `overwrite_err` goes to 1 and stays 1 until reset, including across a chip erase.
- R5: `busy` rises on the edge that accepts a byte write or lock program and stays high for exactly WRITE_CYCLES cycles. For a chip erase it stays high for exactly ERASE_CYCLES cycles.
- R6: A strobe edge that arrives while `busy` is 1 is ignored. The array is unchanged and the busy period is not restarted.
- R7: A write to an address above the data array changes nothing and does not raise `busy`. A verify read of such an address returns FFh.
- R8: `dout` is registered. One cycle after `prog_en`=1 with `op_sel`=00 it shows the addressed byte. Whenever `prog_en` is 0 or `op_sel` is not 00, it shows FFh.
- R9: A lock program ORs `din[2:0]` into the lock bits. While bit 0 is set, byte writes are refused, with no change and no `busy`. While bit 1 is set, verify reads return LOCKED_VALUE (default 00h).
- R10: A chip erase is accepted whatever the lock bits are. It sets every byte of both arrays to FFh and clears all lock bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset to as-shipped state |
| prog_en | input | 1 | Programming-enable level gating all operations |
| op_sel | input | 2 | Operation code |
| addr | input | ADDR_W | Byte address in the combined space |
| din | input | 8 | Write data, or lock bits in [2:0] |
| strobe | input | 1 | Program strobe, acted on at its rising edge |
| dout | output | 8 | Registered verify data |
| busy | output | 1 | Self-timed operation in progress |
| overwrite_err | output | 1 | Sticky flag: a write hit a non-blank byte |

## Verification
The bench writes the first and last byte of each array and reads the data array at an offset it has already used in the code array. A decoder with a wrong boundary or a folded data index would then return the wrong byte. A second write to a programmed byte must read back as the AND of the two values, which exposes a design that overwrites the byte. A strobe pulse during busy must leave both its target byte and the remaining busy length untouched, which catches a design that restarts its timer. The lock sequence then checks three things in turn: a refused write, masked verify data, and an erase that restores both contents and permissions while the error flag survives.

// File: rtl/nvpp_pkg.sv
// Shared types and constants for the parallel programming sequencer.
// Assumes: byte-wide arrays whose erased value is all ones.
package nvpp_pkg;
    typedef enum logic [1:0] {
        OP_VERIFY = 2'b00,
        OP_WRITE  = 2'b01,
        OP_LOCK   = 2'b10,
        OP_ERASE  = 2'b11
    } nvpp_op_e;

    typedef enum logic [1:0] {
        RGN_CODE = 2'b00,
        RGN_DATA = 2'b01,
        RGN_NONE = 2'b10
    } nvpp_rgn_e;

    localparam logic [7:0] BLANK     = 8'hFF;
    localparam int         LOCK_BITS = 3;
endpackage

// File: rtl/nvpp_region_decode.sv
// Splits a flat byte address into a code-array index or a data-array index.
// Assumes: the code array size is a power of two, the data array starts right
// above it, and DATA_AW <= CODE_AW, so the low address bits are the data offset.
module nvpp_region_decode #(
    parameter int ADDR_W  = 14,
    parameter int CODE_AW = 11,
    parameter int DATA_AW = 9
) (
    input  logic [ADDR_W-1:0]    addr,
    output nvpp_pkg::nvpp_rgn_e  rgn,
    output logic [CODE_AW-1:0]   code_idx,
    output logic [DATA_AW-1:0]   data_idx
);
    localparam logic [ADDR_W:0] CODE_END = (ADDR_W+1)'(2**CODE_AW);
    localparam logic [ADDR_W:0] DATA_END = (ADDR_W+1)'(2**CODE_AW + 2**DATA_AW);

    // Region select by comparing against the two upper bounds.
    always_comb begin
        code_idx = addr[CODE_AW-1:0];
        data_idx = addr[DATA_AW-1:0];
        if ({1'b0, addr} < CODE_END)
            rgn = nvpp_pkg::RGN_CODE;
        else if ({1'b0, addr} < DATA_END)
            rgn = nvpp_pkg::RGN_DATA;
        else
            rgn = nvpp_pkg::RGN_NONE;
    end
endmodule

// File: rtl/nvpp_byte_store.sv
// One register-modelled non-volatile byte array.
// Writes can only clear bits (AND with the new byte); erase sets all bytes to ones.
// Assumes: the caller never requests write and erase in the same cycle.
module nvpp_byte_store #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          erase,
    input  logic          wr_en,
    input  logic [AW-1:0] idx,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 2**AW;

    logic [7:0] cells [DEPTH];

    // Cell update: blank on reset or erase, otherwise a 1-to-0 only program.
    always_ff @(posedge clk) begin
        if (!rst_n || erase) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= nvpp_pkg::BLANK;
        end else if (wr_en) begin
            cells[idx] <= cells[idx] & wdata;
        end
    end

    // Asynchronous read port for verify and blank check.
    assign rdata = cells[idx];

    assert_erase_excl_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(erase && wr_en));
    assert_bits_only_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !erase) |=> ((rdata | ~$past(rdata)) == ~$past(rdata) | rdata)
                              && ($stable(idx) -> ((rdata & ~$past(rdata)) == 8'h00)));
endmodule

// File: rtl/nvpp_lock_policy.sv
// Holds the lock bits and turns them into operation permissions.
// Bit 0 forbids byte writes, bit 1 masks verify data, bit 2 is stored only.
// Assumes: bits are only ever set by programming and cleared by chip erase.
module nvpp_lock_policy (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          set_en,
    input  logic [nvpp_pkg::LOCK_BITS-1:0] set_bits,
    input  logic                          clear,
    output logic [nvpp_pkg::LOCK_BITS-1:0] lock_q,
    output logic                          allow_write,
    output logic                          allow_verify
);
    // Lock register: sticky OR on programming, cleared by erase or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            lock_q <= '0;
        else if (set_en)
            lock_q <= lock_q | set_bits;
    end

    // Permission decode from individual lock bits.
    assign allow_write  = ~lock_q[0];
    assign allow_verify = ~lock_q[1];

    assert_lock_monotone_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> ((lock_q & $past(lock_q)) == $past(lock_q)));
    assert_erase_unlocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (lock_q == '0));
endmodule

// File: rtl/nvpp_busy_timer.sv
// Self-timed operation counter: loaded on acceptance, busy while non-zero.
// Assumes: loads happen only while idle and both cycle counts are at least 1.
module nvpp_busy_timer #(
    parameter int WRITE_CYCLES = 64,
    parameter int ERASE_CYCLES = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_wr,
    input  logic load_er,
    output logic busy
);
    localparam int MAXC = (WRITE_CYCLES > ERASE_CYCLES) ? WRITE_CYCLES : ERASE_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;

    // Down-counter holding the remaining busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load_er)
            cnt <= CW'(ERASE_CYCLES);
        else if (load_wr)
            cnt <= CW'(WRITE_CYCLES);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    assert_load_only_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_wr || load_er) |-> !busy);
    assert_busy_after_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_wr || load_er) |=> busy);
    assert_busy_ends_at_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(cnt) == CW'(1)));
endmodule

// File: rtl/nvm_parallel_programmer.sv
// Parallel programming sequencer for a code array plus a data array sharing one
// address space. Detects strobe rising edges, gates them on enable, busy and
// lock permissions, writes bytes with 1-to-0 semantics, programs lock bits,
// performs chip erase, and serves registered verify reads.
// Assumes: inputs are synchronous to clk; reset models the as-shipped state.
module nvm_parallel_programmer #(
    parameter int         ADDR_W       = 14,
    parameter int         CODE_AW      = 11,
    parameter int         DATA_AW      = 9,
    parameter int         WRITE_CYCLES = 64,
    parameter int         ERASE_CYCLES = 256,
    parameter logic [7:0] LOCKED_VALUE = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic [1:0]        op_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    input  logic              strobe,
    output logic [7:0]        dout,
    output logic              busy,
    output logic              overwrite_err
);
    import nvpp_pkg::*;

    nvpp_op_e                op;
    nvpp_rgn_e               rgn;
    logic [CODE_AW-1:0]      code_idx;
    logic [DATA_AW-1:0]      data_idx;
    logic [7:0]              code_rd, data_rd, byte_now;
    logic [LOCK_BITS-1:0]    lock_q;
    logic                    allow_write, allow_verify;
    logic                    strobe_q, fire, go;
    logic                    acc_write, acc_lock, acc_erase;
    logic                    code_wr, data_wr;

    assign op = nvpp_op_e'(op_sel);

    // Strobe history for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe;
    end

    // Acceptance: one edge, enabled, idle, then per-operation permission.
    always_comb begin
        fire      = strobe & ~strobe_q;
        go        = fire & prog_en & ~busy;
        acc_write = go && (op == OP_WRITE) && allow_write && (rgn != RGN_NONE);
        acc_lock  = go && (op == OP_LOCK);
        acc_erase = go && (op == OP_ERASE);
        code_wr   = acc_write && (rgn == RGN_CODE);
        data_wr   = acc_write && (rgn == RGN_DATA);
    end

    nvpp_region_decode #(
        .ADDR_W (ADDR_W),
        .CODE_AW(CODE_AW),
        .DATA_AW(DATA_AW)
    ) u_decode (
        .addr    (addr),
        .rgn     (rgn),
        .code_idx(code_idx),
        .data_idx(data_idx)
    );

    nvpp_byte_store #(.AW(CODE_AW)) u_code (
        .clk  (clk),
        .rst_n(rst_n),
        .erase(acc_erase),
        .wr_en(code_wr),
        .idx  (code_idx),
        .wdata(din),
        .rdata(code_rd)
    );

    nvpp_byte_store #(.AW(DATA_AW)) u_data (
        .clk  (clk),
        .rst_n(rst_n),
        .erase(acc_erase),
        .wr_en(data_wr),
        .idx  (data_idx),
        .wdata(din),
        .rdata(data_rd)
    );

    nvpp_lock_policy u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_en      (acc_lock),
        .set_bits    (din[LOCK_BITS-1:0]),
        .clear       (acc_erase),
        .lock_q      (lock_q),
        .allow_write (allow_write),
        .allow_verify(allow_verify)
    );

    nvpp_busy_timer #(
        .WRITE_CYCLES(WRITE_CYCLES),
        .ERASE_CYCLES(ERASE_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_wr(acc_write | acc_lock),
        .load_er(acc_erase),
        .busy   (busy)
    );

    // Addressed byte; unmapped addresses look blank.
    always_comb begin
        case (rgn)
            RGN_CODE: byte_now = code_rd;
            RGN_DATA: byte_now = data_rd;
            default:  byte_now = BLANK;
        endcase
    end

    // Sticky overwrite flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            overwrite_err <= 1'b0;
        else if (acc_write && (byte_now != BLANK))
            overwrite_err <= 1'b1;
    end

    // Registered verify output with lock masking.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout <= BLANK;
        else if (!(prog_en && (op == OP_VERIFY)))
            dout <= BLANK;
        else if (!allow_verify)
            dout <= LOCKED_VALUE;
        else
            dout <= byte_now;
    end

    assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        overwrite_err |=> overwrite_err);
    assert_busy_strobe_no_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && strobe && !strobe_q) |=> $stable(lock_q));
    assert_unmapped_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en && (op == OP_VERIFY) && (rgn == RGN_NONE) && allow_verify) |=> (dout == BLANK));
    assert_disabled_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_en |=> (dout == BLANK));
endmodule

// File: tb/nvm_parallel_programmer_test.sv
`timescale 1ns/1ps
module nvm_parallel_programmer_test;
    localparam int WR_CYC = 8;
    localparam int ER_CYC = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_en = 1'b0;
    logic [1:0]  op_sel = 2'b00;
    logic [13:0] addr = '0;
    logic [7:0]  din = '0;
    logic        strobe = 1'b0;
    logic [7:0]  dout;
    logic        busy;
    logic        overwrite_err;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    nvm_parallel_programmer #(
        .ADDR_W(14), .CODE_AW(11), .DATA_AW(9),
        .WRITE_CYCLES(WR_CYC), .ERASE_CYCLES(ER_CYC), .LOCKED_VALUE(8'h00)
    ) uut (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .op_sel(op_sel),
        .addr(addr), .din(din), .strobe(strobe),
        .dout(dout), .busy(busy), .overwrite_err(overwrite_err)
    );

    // Vector fields: [31:30] op, [29:16] address, [15:8] data, [7:0] expected read-back.
    localparam int NV = 10;
    localparam logic [31:0] VEC [NV] = '{
        {2'b00, 14'h0000, 8'h00, 8'hFF},  // R2 erased code byte
        {2'b01, 14'h0005, 8'hA5, 8'hA5},  // R1 code write
        {2'b01, 14'h07FF, 8'h3C, 8'h3C},  // R1 last code byte
        {2'b01, 14'h0800, 8'h12, 8'h12},  // R1 first data byte
        {2'b01, 14'h09FF, 8'h81, 8'h81},  // R1 last data byte
        {2'b01, 14'h0A00, 8'h00, 8'hFF},  // R7 just above data array
        {2'b01, 14'h0005, 8'hF0, 8'hA0},  // R4 AND on rewrite
        {2'b00, 14'h0006, 8'h00, 8'hFF},  // R4 neighbour untouched
        {2'b01, 14'h3FFF, 8'h00, 8'hFF},  // R7 top of address space
        {2'b00, 14'h0805, 8'h00, 8'hFF}   // R1 data offset not aliased to code
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic strobe_op(input logic [1:0] o, input logic [13:0] a, input logic [7:0] d);
        @(negedge clk);
        op_sel = o; addr = a; din = d; strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
    endtask

    task automatic wait_idle();
        for (int g = 0; g < 1000 && busy; g++) @(negedge clk);
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic read_at(input logic [13:0] a, output logic [7:0] v);
        @(negedge clk);
        op_sel = 2'b00; addr = a;
        @(negedge clk);
        v = dout;
    endtask

    initial begin
        logic [7:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 busy after reset", {31'b0, busy}, 0);
        check("R2 dout after reset", {24'b0, dout}, 32'hFF);
        check("R2 err after reset", {31'b0, overwrite_err}, 0);
        prog_en = 1'b1;

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][31:30] != 2'b00) begin
                strobe_op(VEC[i][31:30], VEC[i][29:16], VEC[i][15:8]);
                wait_idle();
            end
            read_at(VEC[i][29:16], v);
            check($sformatf("R1/R4/R7 vector %0d", i), {24'b0, v}, {24'b0, VEC[i][7:0]});
        end
        check("R4 error set by rewrite", {31'b0, overwrite_err}, 1);

        // R5: exact write busy length
        strobe_op(2'b01, 14'h0040, 8'h77);
        count_busy(n);
        check("R5 write busy cycles", n, WR_CYC);

        // R6: strobe during busy ignored and timer not restarted
        strobe_op(2'b01, 14'h0010, 8'h0F);
        strobe_op(2'b01, 14'h0011, 8'h00);
        count_busy(n);
        check("R6 busy not restarted", n, WR_CYC - 2);
        read_at(14'h0011, v);
        check("R6 second target untouched", {24'b0, v}, 32'hFF);
        read_at(14'h0010, v);
        check("R6 first write landed", {24'b0, v}, 32'h0F);

        // R7: unmapped write raises no busy
        strobe_op(2'b01, 14'h0A00, 8'h00);
        check("R7 no busy on unmapped write", {31'b0, busy}, 0);

        // R3/R8: enable low refuses writes and blanks verify
        prog_en = 1'b0;
        strobe_op(2'b01, 14'h0020, 8'h00);
        check("R3 no busy while disabled", {31'b0, busy}, 0);
        read_at(14'h0005, v);
        check("R8 disabled read is FF", {24'b0, v}, 32'hFF);
        prog_en = 1'b1;
        read_at(14'h0020, v);
        check("R3 disabled write had no effect", {24'b0, v}, 32'hFF);

        // R9: write lock
        strobe_op(2'b10, 14'h0000, 8'h01);
        count_busy(n);
        check("R5 lock busy cycles", n, WR_CYC);
        strobe_op(2'b01, 14'h0030, 8'h00);
        check("R9 locked write no busy", {31'b0, busy}, 0);
        read_at(14'h0030, v);
        check("R9 locked write no change", {24'b0, v}, 32'hFF);
        read_at(14'h0005, v);
        check("R9 verify still allowed", {24'b0, v}, 32'hA0);

        // R9: verify lock
        strobe_op(2'b10, 14'h0000, 8'h02);
        wait_idle();
        read_at(14'h0005, v);
        check("R9 masked verify", {24'b0, v}, 32'h00);

        // R10: chip erase despite locks
        strobe_op(2'b11, 14'h0000, 8'h00);
        count_busy(n);
        check("R5 erase busy cycles", n, ER_CYC);
        read_at(14'h0005, v);
        check("R10 code blank after erase", {24'b0, v}, 32'hFF);
        read_at(14'h09FF, v);
        check("R10 data blank after erase", {24'b0, v}, 32'hFF);
        strobe_op(2'b01, 14'h0030, 8'h55);
        wait_idle();
        read_at(14'h0030, v);
        check("R10 locks cleared by erase", {24'b0, v}, 32'h55);
        check("R4 error survives erase", {31'b0, overwrite_err}, 1);

        // R2: reset returns to shipped state
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R2 err cleared by reset", {31'b0, overwrite_err}, 0);
        read_at(14'h0030, v);
        check("R2 array blank after reset", {24'b0, v}, 32'hFF);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule